// File: doc/BRIEF.md
# Nibble-Mode Parallel Register Slave

This block is the device end of a network adapter attached to a host parallel port. The host has no strobe lines. Every command and every data value reaches the device as a byte placed on the eight data lines. The device samples that byte through a two-flop synchronizer and acts only when the synchronized value changes. Holding a byte, or driving the same byte again, therefore causes nothing new.

The top three bits of each byte are an opcode. Bit 4 chooses the upper or lower half of an 8-bit register. The low four bits carry either a register index or a data nibble.

Through this scheme the host reaches fourteen 8-bit registers and a byte-stream memory port (index 14). The memory port uses an auto-incrementing pointer. Read data returns four bits at a time on a 5-bit status bus. The host can also clear every register and the pointer by writing one command bit.

Top module: `nibble_port_slave`

## Requirements
- R1: After reset, status_out is 0, mem_we is 0, mem_addr is 0, and every register reads back as 0.
- R2: Bits 7:5 of a byte are the opcode: 111 idle (ends any cycle), 110 read, 010 write-address, 000 data. Other opcodes are ignored. Bit 4 selects the upper half (1) or lower half (0), and bits 3:0 carry the index or nibble.
- R3: A read cycle is 111|h|idx, then 110|h|idx. After it, status_out[4] is 1 and status_out[3:0] holds the selected nibble. Both stay until the next 111 byte, which returns status_out to 0. Whenever status_out[4] is 0, status_out[3:0] is 0.
- R4: A write cycle is 111|h|idx, 010|h|idx, 010|h|d, 000|h|d, 111. The nibble d from the 000 byte is stored in the half of register idx chosen by h at address time. The other half is unchanged.
- R5: At most one nibble is committed per write cycle. A further 000 byte before the next 111 is ignored, and so is a 000 byte that has no preceding address phase.
- R6: A byte held on the lines for many cycles acts once. A completed stream byte produces exactly one single-cycle mem_we pulse.
- R7: Index 15 reads as 0 and ignores writes. A write to one register leaves every other register unchanged.
- R8: After the address phase 111|14, 010|14, each pair of data bytes 0x0L then 0x1H writes {H,L} to mem_addr and then advances mem_addr by one. A 0x1H byte with no pending low nibble is ignored.
- R9: The read 110|14 returns mem_rdata[3:0], and the read 110|1|14 returns mem_rdata[7:4]. mem_addr advances by one after the upper-half read.
- R10: Writing a 1 into bit 2 of the upper half of register 12 clears all registers and returns mem_addr to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 8 | Asynchronous data lines from the host |
| status_out | output | 5 | [4] read data valid, [3:0] returned nibble |
| mem_addr | output | AW | Stream pointer / memory address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_addr |

## Verification
Several properties are checked on every clock cycle:
- each stream write advances the pointer by exactly one, and a write strobe never lasts two cycles;
- an upper-half stream read advances the pointer;
- the status nibble is zero whenever it is not flagged valid;
- no two commits fall on consecutive cycles;
- a clear always leaves the pointer at zero.

The bench scenarios show the behaviour that needs multi-byte context:
- which half and which register a write reaches;
- that surplus data bytes and index 15 are ignored;
- how stream nibble pairs assemble into bytes;
- the values returned by reads before and after a register clear.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam logic [2:0] OP_DATA  = 3'b000;
  localparam logic [2:0] OP_WADDR = 3'b010;
  localparam logic [2:0] OP_RADDR = 3'b110;
  localparam logic [2:0] OP_IDLE  = 3'b111;

  localparam logic [3:0] IDX_CMD1 = 4'd12;
  localparam logic [3:0] IDX_PORT = 4'd14;
  localparam int         CMD1_CLR_BIT = 2;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_READ,
    DS_WADDR,
    DS_DONE
  } dec_state_e;
endpackage

// File: rtl/nps_sync.sv
module nps_sync #(
  parameter int          W        = 8,
  parameter logic [W-1:0] IDLE_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         evt
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= IDLE_VAL;
      sync_q <= IDLE_VAL;
      prev_q <= IDLE_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign dout = sync_q;
  assign evt  = (sync_q != prev_q);
endmodule

// File: rtl/nps_decoder.sv
module nps_decoder
  import nps_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic [DW-1:0] byte_in,
  output logic          rf_we,
  output logic [3:0]    rf_idx,
  output logic          rf_hi,
  output logic [3:0]    rf_nib,
  output logic          rd_load,
  output logic          rd_clear,
  output logic [3:0]    rd_idx,
  output logic          rd_hi,
  output logic          st_we,
  output logic [DW-1:0] st_byte
);
  dec_state_e state_q;
  logic [3:0] wr_idx_q;
  logic       wr_hi_q;
  logic [3:0] lo_q;
  logic       have_lo_q;

  logic [2:0] op;
  logic       b_hi;
  logic [3:0] b_low;
  assign op    = byte_in[7:5];
  assign b_hi  = byte_in[4];
  assign b_low = byte_in[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= DS_IDLE;
      wr_idx_q  <= '0;
      wr_hi_q   <= 1'b0;
      lo_q      <= '0;
      have_lo_q <= 1'b0;
      rf_we     <= 1'b0;
      rf_idx    <= '0;
      rf_hi     <= 1'b0;
      rf_nib    <= '0;
      rd_load   <= 1'b0;
      rd_clear  <= 1'b0;
      rd_idx    <= '0;
      rd_hi     <= 1'b0;
      st_we     <= 1'b0;
      st_byte   <= '0;
    end else begin
      rf_we    <= 1'b0;
      rd_load  <= 1'b0;
      rd_clear <= 1'b0;
      st_we    <= 1'b0;
      if (evt) begin
        case (op)
          OP_IDLE: begin
            state_q   <= DS_IDLE;
            have_lo_q <= 1'b0;
            rd_clear  <= 1'b1;
          end
          OP_RADDR: begin
            state_q <= DS_READ;
            rd_idx  <= b_low;
            rd_hi   <= b_hi;
            rd_load <= 1'b1;
          end
          OP_WADDR: begin
            if (state_q == DS_IDLE) begin
              state_q  <= DS_WADDR;
              wr_idx_q <= b_low;
              wr_hi_q  <= b_hi;
            end
          end
          OP_DATA: begin
            if (state_q == DS_WADDR) begin
              if (wr_idx_q == IDX_PORT) begin
                if (!b_hi) begin
                  lo_q      <= b_low;
                  have_lo_q <= 1'b1;
                end else if (have_lo_q) begin
                  st_we     <= 1'b1;
                  st_byte   <= DW'({b_low, lo_q});
                  have_lo_q <= 1'b0;
                end
              end else begin
                rf_we   <= 1'b1;
                rf_idx  <= wr_idx_q;
                rf_hi   <= wr_hi_q;
                rf_nib  <= b_low;
                state_q <= DS_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_single_commit_R5: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
endmodule

// File: rtl/nps_regfile.sv
module nps_regfile
  import nps_pkg::*;
#(
  parameter int NUM_REGS = 14,
  parameter int DW       = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [3:0] idx,
  input  logic       hi,
  input  logic [3:0] nib,
  input  logic [3:0] rd_idx,
  input  logic       rd_hi,
  output logic [3:0] rd_nib,
  output logic       soft_clr
);
  logic [DW-1:0] regs [NUM_REGS];
  logic          clr_now;

  assign clr_now = we && (idx == IDX_CMD1) && hi && nib[CMD1_CLR_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || clr_now) begin
        regs[i] <= '0;
      end else if (we && (int'(idx) == i)) begin
        if (hi) regs[i][7:4] <= nib;
        else    regs[i][3:0] <= nib;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) soft_clr <= 1'b0;
    else     soft_clr <= clr_now;
  end

  always_comb begin
    rd_nib = '0;
    if (int'(rd_idx) < NUM_REGS) begin
      rd_nib = rd_hi ? regs[rd_idx][7:4] : regs[rd_idx][3:0];
    end
  end
endmodule

// File: rtl/nps_stream_port.sv
module nps_stream_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_we,
  input  logic [DW-1:0] st_byte,
  input  logic          rd_inc,
  input  logic          clr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_addr
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= st_we;
      if (st_we) mem_wdata <= st_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)             ptr_q <= '0;
    else if (mem_we || rd_inc)  ptr_q <= ptr_q + AW'(1);
  end

  assign mem_addr = ptr_q;

  assert_ptr_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_addr == $past(mem_addr) + AW'(1)));
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_ptr_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_inc && !clr) |=> (mem_addr == $past(mem_addr) + AW'(1)));
  assert_clear_ptr_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mem_addr == '0));
endmodule

// File: rtl/nibble_port_slave.sv
module nibble_port_slave
  import nps_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NUM_REGS = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    host_data,
  output logic [4:0]    status_out,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata
);
  localparam int DW = 8;

  logic [DW-1:0] sbyte;
  logic          evt;
  logic          rf_we, rf_hi, rd_load, rd_clear, rd_hi, st_we, soft_clr;
  logic [3:0]    rf_idx, rf_nib, rd_idx, rf_rd_nib;
  logic [DW-1:0] st_byte;
  logic          port_sel, rd_inc;
  logic [3:0]    sel_nib;
  logic [4:0]    status_q;

  nps_sync #(.W(DW), .IDLE_VAL({OP_IDLE, 5'b0})) u_sync (
    .clk(clk), .rst(rst), .din(host_data), .dout(sbyte), .evt(evt));

  nps_decoder #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .evt(evt), .byte_in(sbyte),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_hi(rf_hi), .rf_nib(rf_nib),
    .rd_load(rd_load), .rd_clear(rd_clear), .rd_idx(rd_idx), .rd_hi(rd_hi),
    .st_we(st_we), .st_byte(st_byte));

  nps_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .idx(rf_idx), .hi(rf_hi), .nib(rf_nib),
    .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_nib(rf_rd_nib), .soft_clr(soft_clr));

  assign port_sel = (rd_idx == IDX_PORT);
  assign rd_inc   = rd_load && port_sel && rd_hi;
  assign sel_nib  = port_sel ? (rd_hi ? mem_rdata[7:4] : mem_rdata[3:0]) : rf_rd_nib;

  nps_stream_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .st_we(st_we), .st_byte(st_byte), .rd_inc(rd_inc),
    .clr(soft_clr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_addr(mem_addr));

  always_ff @(posedge clk) begin
    if (rst || rd_clear) status_q <= '0;
    else if (rd_load)    status_q <= {1'b1, sel_nib};
  end

  assign status_out = status_q;

  assert_quiet_status_R3: assert property (@(posedge clk) disable iff (rst)
    !status_out[4] |-> (status_out[3:0] == 4'h0));
endmodule

// File: tb/sim_nibble_port_slave.sv
module sim_nibble_port_slave;
  localparam int AW = 8;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    host_data = 8'hE0;
  logic [4:0]    status_out;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_we;
  logic [7:0]    mem_rdata = 8'h00;
  logic [7:0]    bmem [256];
  int            tests = 0, fails = 0, we_cnt = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  nibble_port_slave #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .host_data(host_data), .status_out(status_out),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata;
    mem_rdata <= bmem[mem_addr];
    if (!rst && mem_we) we_cnt <= we_cnt + 1;
  end

  // {read, hi, idx, nib, expected}
  localparam int NV = 20;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0,1'b0,4'd0, 4'hA,4'h0}, {1'b0,1'b1,4'd0, 4'h5,4'h0},
    {1'b1,1'b0,4'd0, 4'h0,4'hA}, {1'b1,1'b1,4'd0, 4'h0,4'h5},
    {1'b0,1'b0,4'd3, 4'h7,4'h0}, {1'b1,1'b0,4'd0, 4'h0,4'hA},
    {1'b1,1'b0,4'd3, 4'h0,4'h7}, {1'b1,1'b1,4'd3, 4'h0,4'h0},
    {1'b0,1'b1,4'd13,4'hC,4'h0}, {1'b1,1'b1,4'd13,4'h0,4'hC},
    {1'b1,1'b0,4'd13,4'h0,4'h0}, {1'b0,1'b0,4'd15,4'h9,4'h0},
    {1'b1,1'b0,4'd15,4'h0,4'h0}, {1'b0,1'b1,4'd11,4'hF,4'h0},
    {1'b1,1'b1,4'd11,4'h0,4'hF}, {1'b0,1'b0,4'd12,4'h3,4'h0},
    {1'b1,1'b0,4'd12,4'h0,4'h3}, {1'b0,1'b1,4'd12,4'h3,4'h0},
    {1'b1,1'b1,4'd12,4'h0,4'h3}, {1'b1,1'b1,4'd0, 4'h0,4'h5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk) host_data = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] idx, input logic hi, input logic [3:0] nib);
    put({3'b111, hi, idx});
    put({3'b010, hi, idx});
    put({3'b010, hi, nib});
    put({3'b000, hi, nib});
    put({3'b111, hi, nib});
  endtask

  task automatic reg_read(input logic [3:0] idx, input logic hi, output logic [4:0] st);
    put({3'b111, hi, idx});
    put({3'b110, hi, idx});
    st = status_out;
    put({3'b111, hi, idx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] st;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 status", status_out, 5'h00);
    chk("R1 mem_we", mem_we, 1'b0);
    chk("R1 mem_addr", mem_addr, 0);
    reg_read(4'd5, 1'b0, st);
    chk("R1 reg5 reads zero", st, 5'h10);

    // table of register writes and reads (R2 R4 R7)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][13]) begin
        reg_read(VEC[i][11:8], VEC[i][12], st);
        chk($sformatf("R4/R7 vector %0d", i), st, {1'b1, VEC[i][3:0]});
      end else begin
        reg_write(VEC[i][11:8], VEC[i][12], VEC[i][7:4]);
      end
    end

    // R3 status held until idle, then dropped
    put(8'hE3); put(8'hC3);
    repeat (20) @(negedge clk);
    chk("R3 held nibble", status_out, 5'h17);
    put(8'hE3);
    chk("R3 idle drops status", status_out, 5'h00);

    // R2 unknown opcode ignored: 001 byte while reading
    put(8'hE0); put(8'hC0); put(8'h2F);
    chk("R2 unknown opcode no effect", status_out, 5'h1A);
    put(8'hE0);

    // R5 extra data byte ignored, orphan data ignored
    put(8'hE1); put(8'h41); put(8'h44); put(8'h04); put(8'h09); put(8'hE9);
    put(8'h06); put(8'hE6);
    reg_read(4'd1, 1'b0, st);
    chk("R5 single commit", st, 5'h14);

    // R8 / R6 stream writes
    put(8'hEE); put(8'h4E);
    put(8'h0C); put(8'h13);
    repeat (40) @(negedge clk);
    chk("R6 one strobe for held byte", we_cnt, 1);
    chk("R8 pointer after byte", mem_addr, 1);
    put(8'h0F); put(8'h1E); put(8'h0E); put(8'h1B);
    put(8'h17);
    put(8'hE0);
    chk("R8 strobes for word, orphan high ignored", we_cnt, 3);
    chk("R8 pointer after word", mem_addr, 3);
    chk("R8 byte0", bmem[0], 8'h3C);
    chk("R8 byte1", bmem[1], 8'hEF);
    chk("R8 byte2", bmem[2], 8'hBE);

    // R10 clear via command register 1 upper bit 2
    reg_write(4'd12, 1'b1, 4'h4);
    chk("R10 pointer cleared", mem_addr, 0);
    reg_read(4'd0, 1'b0, st);
    chk("R10 reg0 cleared", st, 5'h10);
    reg_read(4'd11, 1'b1, st);
    chk("R10 reg11 cleared", st, 5'h10);

    // R9 stream reads
    put(8'hEE); put(8'hCE);
    chk("R9 low nibble byte0", status_out, 5'h1C);
    chk("R9 pointer holds after low", mem_addr, 0);
    put(8'hDE);
    chk("R9 high nibble byte0", status_out, 5'h13);
    chk("R9 pointer after high", mem_addr, 1);
    put(8'hCE);
    chk("R9 low nibble byte1", status_out, 5'h1F);
    put(8'hDE);
    chk("R9 high nibble byte1", status_out, 5'h1E);
    put(8'hE0);
    chk("R9 pointer after two bytes", mem_addr, 2);

    // R1 hard reset mid-operation
    put(8'hC3);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; host_data = 8'hE0;
    @(negedge clk);
    chk("R1 status after reset", status_out, 5'h00);
    chk("R1 pointer after reset", mem_addr, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule